// File: doc/BRIEF.md
# Frame-Paced Auxiliary Conversion Scheduler

This block decides when an auxiliary ADC channel gets sampled. It counts frame ticks (one pulse per 48 kHz audio-link frame) and produces three kinds of output: the analog multiplexer select, a one-cycle sample strobe and a tagged result-valid pulse. Every conversion is paced in whole frames. A settling-delay code adds frames before the sample. The all-ones delay code is a hold setting: it pins the multiplexer to the addressed input and skips the per-conversion settling.

Work is started in one of two ways. A single poll request starts one conversion. Continuous mode starts conversions repeatedly, and when the hold setting is active a rate code spaces them. The battery input is read through an internal divider. The divider is switched in only for the frames in which a battery conversion is settling or being converted, and it always stays in for at least two frames. A two-bit power mode of zero turns off the pen-detect enable and stops all conversion activity.

Top module: `aux_conv_sched`

## Requirements
- R1: After reset, sample_strobe, res_valid, res_chan, batt_div_en and adc_mux are all zero.
- R2: While power_mode is 2'b00, pen_det_en is low and no strobe, result or divider enable appears. Any state in progress is dropped, including a held poll. Any other power_mode drives pen_det_en high.
- R3: chan_sel codes 1 (auxiliary), 2 (battery), 3 (shared A) and 4 (shared B) are valid. A request on codes 0, 5, 6 or 7 produces no conversion.
- R4: With delay code d below 15, a poll starts at the first frame tick after the request. The strobe follows d+1 ticks after that start tick, and adc_mux shows the channel while the conversion settles.
- R5: res_valid is a one-cycle pulse in the cycle after the frame tick that follows the strobe's frame tick. res_chan carries the converted channel code.
- R6: With delay code 15, adc_mux follows chan_sel continuously. A non-battery conversion strobes on its start tick.
- R7: In continuous mode with delay code 15 on a non-battery channel, rate codes 0, 1, 2 and 3 space strobes 1, 2, 4 and 6 frame ticks apart.
- R8: batt_div_en is high from the start tick of a battery conversion until its result tick, for d+2 frames and never fewer than two. Under delay code 15 a battery conversion takes one settling frame.
- R9: batt_div_en stays low for non-battery conversions and whenever no battery conversion is pending or active.
- R10: A poll request that arrives while a conversion is in progress is held. It starts on the frame tick after the result tick.
- R11: Outside continuous mode, rate_code has no effect on conversion timing.
- R12: In continuous mode with delay code d below 15, conversions repeat every d+3 frame ticks.
- R13: sample_strobe is high only in the cycle after a frame tick, so there is at most one strobe per frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| frame_tick | input | 1 | One-cycle pulse per link frame |
| power_mode | input | 2 | 00 powers the scheduler and pen detection down |
| cont_en | input | 1 | Continuous conversion mode |
| poll_req | input | 1 | One-cycle request for a single conversion |
| chan_sel | input | 3 | Addressed input (1 aux, 2 battery, 3 shared A, 4 shared B) |
| delay_code | input | 4 | Settling frames minus one; 15 holds the channel |
| rate_code | input | 2 | Frames per sample in continuous hold mode |
| adc_mux | output | 3 | Channel routed to the converter, 0 when none |
| sample_strobe | output | 1 | One-cycle sample command |
| batt_div_en | output | 1 | Battery divider switched in |
| pen_det_en | output | 1 | Pen-down detection enabled |
| res_valid | output | 1 | One-cycle result pulse |
| res_chan | output | 3 | Channel tag of the result, 0 when idle |

## Verification
The bench targets off-by-one pacing in three places: settle latency against the delay code, result latency after the strobe, and strobe spacing for each rate code. A design that miscounts frames shows a strobe or result one tick early or late. It also checks that the battery divider covers exactly the settle and convert frames, and that a battery conversion under the hold code still gets two frames. A design that treats battery like any other held channel would show the divider for only one frame. Further cases are a poll queued during a busy conversion (lost, or started too early), invalid channel codes, a rate code changed during poll mode, and power-down in the middle of a battery conversion (divider left on or a stale result). Random channel, delay and rate combinations are checked against latencies computed by bench functions.

// File: rtl/aux_sched_pkg.sv
package aux_sched_pkg;
    localparam int CH_W    = 3;
    localparam int DLY_W   = 4;
    localparam int RATE_W  = 2;
    localparam int PWR_W   = 2;
    localparam int PACE_W  = 3;

    localparam logic [DLY_W-1:0] HOLD_CODE = '1;

    localparam logic [CH_W-1:0] CH_NONE  = 3'd0;
    localparam logic [CH_W-1:0] CH_AUX   = 3'd1;
    localparam logic [CH_W-1:0] CH_BATT  = 3'd2;
    localparam logic [CH_W-1:0] CH_SHR_A = 3'd3;
    localparam logic [CH_W-1:0] CH_SHR_B = 3'd4;

    typedef enum logic {ST_IDLE, ST_SETTLE} conv_state_e;

    typedef struct packed {
        logic            busy;
        logic [CH_W-1:0] tag;
    } res_slot_t;

    function automatic logic chan_ok(input logic [CH_W-1:0] c);
        return (c >= CH_AUX) && (c <= CH_SHR_B);
    endfunction

    // frames between continuous strobes, minus one
    function automatic logic [PACE_W-1:0] pace_reload(input logic [RATE_W-1:0] r);
        case (r)
            2'd0:    return 3'd0;
            2'd1:    return 3'd1;
            2'd2:    return 3'd3;
            default: return 3'd5;
        endcase
    endfunction
endpackage

// File: rtl/aux_rate_pacer.sv
module aux_rate_pacer
    import aux_sched_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              tick,
    input  logic              pwr_on,
    input  logic              hold,
    input  logic              cont_en,
    input  logic              start_evt,
    input  logic [RATE_W-1:0] rate_code,
    output logic              pace_ok
);
    logic [PACE_W-1:0] frames_left;

    assign pace_ok = !hold || (frames_left == '0);

    always_ff @(posedge clk) begin
        if (rst || !pwr_on) begin
            frames_left <= '0;
        end else if (tick) begin
            if (start_evt && hold && cont_en)
                frames_left <= pace_reload(rate_code);
            else if (frames_left != '0)
                frames_left <= frames_left - 1'b1;
        end
    end
endmodule

// File: rtl/aux_conv_fsm.sv
module aux_conv_fsm
    import aux_sched_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             tick,
    input  logic             pwr_on,
    input  logic             hold,
    input  logic             cont_en,
    input  logic             poll_req,
    input  logic             pace_ok,
    input  logic             rv_busy,
    input  logic [CH_W-1:0]  chan_sel,
    input  logic [DLY_W-1:0] delay_code,
    output logic             start_evt,
    output logic             strobe_evt,
    output logic [CH_W-1:0]  strobe_tag,
    output logic [CH_W-1:0]  cur_tag,
    output logic             settling
);
    conv_state_e      state;
    logic [DLY_W-1:0] settle_left;
    logic             poll_pend;
    logic             sel_batt;
    logic             fast;
    logic             want;
    logic             can_start;

    always_comb begin
        sel_batt = (chan_sel == CH_BATT);
        fast     = hold && !sel_batt;
        if (cont_en)
            want = fast ? pace_ok : (pace_ok && !rv_busy);
        else
            want = poll_pend && !rv_busy;
        can_start  = tick && pwr_on && (state == ST_IDLE) && want;
        start_evt  = can_start && chan_ok(chan_sel);
        strobe_evt = tick && pwr_on &&
                     ((start_evt && fast) || ((state == ST_SETTLE) && (settle_left == '0)));
        strobe_tag = (state == ST_SETTLE) ? cur_tag : chan_sel;
        settling   = (state == ST_SETTLE);
    end

    always_ff @(posedge clk) begin
        if (rst || !pwr_on) begin
            state       <= ST_IDLE;
            settle_left <= '0;
            poll_pend   <= 1'b0;
            cur_tag     <= CH_NONE;
        end else begin
            if (can_start)
                poll_pend <= poll_req;
            else if (poll_req)
                poll_pend <= 1'b1;

            if (tick) begin
                case (state)
                    ST_IDLE: begin
                        if (start_evt && !fast) begin
                            state       <= ST_SETTLE;
                            settle_left <= hold ? '0 : delay_code;
                            cur_tag     <= chan_sel;
                        end
                    end
                    ST_SETTLE: begin
                        if (settle_left == '0)
                            state <= ST_IDLE;
                        else
                            settle_left <= settle_left - 1'b1;
                    end
                    default: state <= ST_IDLE;
                endcase
            end
        end
    end
endmodule

// File: rtl/aux_result_stage.sv
module aux_result_stage
    import aux_sched_pkg::*;
(
    input  logic            clk,
    input  logic            rst,
    input  logic            tick,
    input  logic            pwr_on,
    input  logic            strobe_evt,
    input  logic [CH_W-1:0] strobe_tag,
    output logic            sample_strobe,
    output logic            res_valid,
    output logic [CH_W-1:0] res_chan,
    output logic            rv_busy,
    output logic [CH_W-1:0] rv_tag
);
    res_slot_t slot;

    assign rv_busy = slot.busy;
    assign rv_tag  = slot.tag;

    always_ff @(posedge clk) begin
        if (rst || !pwr_on) begin
            slot          <= '0;
            sample_strobe <= 1'b0;
            res_valid     <= 1'b0;
            res_chan      <= CH_NONE;
        end else begin
            sample_strobe <= strobe_evt;
            res_valid     <= tick && slot.busy;
            res_chan      <= (tick && slot.busy) ? slot.tag : CH_NONE;
            if (tick) begin
                slot.busy <= strobe_evt;
                if (strobe_evt)
                    slot.tag <= strobe_tag;
            end
        end
    end
endmodule

// File: rtl/aux_conv_sched.sv
module aux_conv_sched
    import aux_sched_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              frame_tick,
    input  logic [PWR_W-1:0]  power_mode,
    input  logic              cont_en,
    input  logic              poll_req,
    input  logic [CH_W-1:0]   chan_sel,
    input  logic [DLY_W-1:0]  delay_code,
    input  logic [RATE_W-1:0] rate_code,
    output logic [CH_W-1:0]   adc_mux,
    output logic              sample_strobe,
    output logic              batt_div_en,
    output logic              pen_det_en,
    output logic              res_valid,
    output logic [CH_W-1:0]   res_chan
);
    logic            pwr_on;
    logic            hold;
    logic            pace_ok;
    logic            start_evt;
    logic            strobe_evt;
    logic [CH_W-1:0] strobe_tag;
    logic [CH_W-1:0] cur_tag;
    logic            settling;
    logic            rv_busy;
    logic [CH_W-1:0] rv_tag;

    assign pwr_on     = (power_mode != '0);
    assign hold       = (delay_code == HOLD_CODE);
    assign pen_det_en = pwr_on;

    aux_rate_pacer u_pacer (
        .clk       (clk),
        .rst       (rst),
        .tick      (frame_tick),
        .pwr_on    (pwr_on),
        .hold      (hold),
        .cont_en   (cont_en),
        .start_evt (start_evt),
        .rate_code (rate_code),
        .pace_ok   (pace_ok)
    );

    aux_conv_fsm u_fsm (
        .clk        (clk),
        .rst        (rst),
        .tick       (frame_tick),
        .pwr_on     (pwr_on),
        .hold       (hold),
        .cont_en    (cont_en),
        .poll_req   (poll_req),
        .pace_ok    (pace_ok),
        .rv_busy    (rv_busy),
        .chan_sel   (chan_sel),
        .delay_code (delay_code),
        .start_evt  (start_evt),
        .strobe_evt (strobe_evt),
        .strobe_tag (strobe_tag),
        .cur_tag    (cur_tag),
        .settling   (settling)
    );

    aux_result_stage u_result (
        .clk           (clk),
        .rst           (rst),
        .tick          (frame_tick),
        .pwr_on        (pwr_on),
        .strobe_evt    (strobe_evt),
        .strobe_tag    (strobe_tag),
        .sample_strobe (sample_strobe),
        .res_valid     (res_valid),
        .res_chan      (res_chan),
        .rv_busy       (rv_busy),
        .rv_tag        (rv_tag)
    );

    always_comb begin
        batt_div_en = pwr_on && ((settling && (cur_tag == CH_BATT)) ||
                                 (rv_busy && (rv_tag == CH_BATT)));
        if (!pwr_on)
            adc_mux = CH_NONE;
        else if (hold)
            adc_mux = chan_sel;
        else if (settling)
            adc_mux = cur_tag;
        else if (rv_busy)
            adc_mux = rv_tag;
        else
            adc_mux = CH_NONE;
    end
endmodule

// File: rtl/aux_sched_chk.sv
module aux_sched_chk (
    input logic       clk,
    input logic       rst,
    input logic       frame_tick,
    input logic [1:0] power_mode,
    input logic       sample_strobe,
    input logic       res_valid,
    input logic [2:0] res_chan,
    input logic       batt_div_en
);
    AST_STROBE_AFTER_TICK: assert property (@(posedge clk) disable iff (rst)
        sample_strobe |-> $past(frame_tick)); // R13

    AST_RESULT_AFTER_TICK: assert property (@(posedge clk) disable iff (rst)
        res_valid |-> $past(frame_tick)); // R5

    AST_POWER_DOWN_QUIET: assert property (@(posedge clk) disable iff (rst)
        ($past(power_mode) == 2'b00) |-> (!sample_strobe && !res_valid && !batt_div_en)); // R2

    AST_BATT_RESULT_DIVIDED: assert property (@(posedge clk) disable iff (rst)
        (res_valid && (res_chan == 3'd2)) |-> $past(batt_div_en)); // R8

    AST_RESULT_TAG_VALID: assert property (@(posedge clk) disable iff (rst)
        res_valid |-> ((res_chan >= 3'd1) && (res_chan <= 3'd4))); // R3
endmodule

bind aux_conv_sched aux_sched_chk u_chk (
    .clk           (clk),
    .rst           (rst),
    .frame_tick    (frame_tick),
    .power_mode    (power_mode),
    .sample_strobe (sample_strobe),
    .res_valid     (res_valid),
    .res_chan      (res_chan),
    .batt_div_en   (batt_div_en)
);

// File: tb/aux_conv_sched_test.sv
module aux_conv_sched_test;
    logic       clk = 1'b0;
    logic       rst;
    logic       frame_tick;
    logic [1:0] power_mode;
    logic       cont_en;
    logic       poll_req;
    logic [2:0] chan_sel;
    logic [3:0] delay_code;
    logic [1:0] rate_code;
    logic [2:0] adc_mux;
    logic       sample_strobe;
    logic       batt_div_en;
    logic       pen_det_en;
    logic       res_valid;
    logic [2:0] res_chan;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 0;

    always #5 clk = ~clk;

    aux_conv_sched uut (
        .clk(clk), .rst(rst), .frame_tick(frame_tick), .power_mode(power_mode),
        .cont_en(cont_en), .poll_req(poll_req), .chan_sel(chan_sel),
        .delay_code(delay_code), .rate_code(rate_code), .adc_mux(adc_mux),
        .sample_strobe(sample_strobe), .batt_div_en(batt_div_en),
        .pen_det_en(pen_det_en), .res_valid(res_valid), .res_chan(res_chan)
    );

    task automatic chk(input string what, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", what, act, exp);
        end
    endtask

    function automatic int exp_strobe(input int d, input bit batt);
        if (d == 15) return batt ? 2 : 1;
        return d + 2;
    endfunction

    function automatic int exp_batt(input int d, input bit batt);
        if (!batt) return 0;
        return (d == 15) ? 2 : d + 2;
    endfunction

    function automatic int exp_period(input int d, input int rate);
        if (d != 15) return d + 3;
        case (rate)
            0: return 1;
            1: return 2;
            2: return 4;
            default: return 6;
        endcase
    endfunction

    // one frame tick; outputs of that edge are visible on return
    task automatic tick();
        @(negedge clk);
        @(negedge clk);
        @(negedge clk) frame_tick = 1'b1;
        @(negedge clk) frame_tick = 1'b0;
    endtask

    task automatic pulse_poll();
        @(negedge clk) poll_req = 1'b1;
        @(negedge clk) poll_req = 1'b0;
    endtask

    task automatic poll_run(input logic [2:0] ch, input logic [3:0] d, input logic [1:0] rate,
                            output int s_at, output int r_at, output int tag,
                            output int bcnt, output int mux1);
        chan_sel = ch; delay_code = d; rate_code = rate; cont_en = 1'b0;
        pulse_poll();
        s_at = 0; r_at = 0; tag = -1; bcnt = 0; mux1 = -1;
        for (int k = 1; k <= 30 && r_at == 0; k++) begin
            tick();
            if (k == 1) mux1 = adc_mux;
            if (sample_strobe && s_at == 0) s_at = k;
            if (res_valid) begin r_at = k; tag = res_chan; end
            if (batt_div_en) bcnt++;
        end
    endtask

    task automatic cont_run(input logic [2:0] ch, input logic [3:0] d, input logic [1:0] rate,
                            output int s1, output int s2, output int nstb, output int nrv);
        chan_sel = ch; delay_code = d; rate_code = rate; cont_en = 1'b1;
        s1 = 0; s2 = 0; nstb = 0; nrv = 0;
        for (int k = 1; k <= 16; k++) begin
            tick();
            if (sample_strobe) begin
                nstb++;
                if (s1 == 0) s1 = k; else if (s2 == 0) s2 = k;
            end
            if (res_valid) nrv++;
        end
        cont_en = 1'b0;
        repeat (10) tick();
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    end

    initial begin
        int s, r, t, b, m, s1, s2, ns, nr;
        int unsigned seed0;
        seed0 = $urandom(32'd4242);
        rst = 1'b1; frame_tick = 1'b0; power_mode = 2'b00; cont_en = 1'b0;
        poll_req = 1'b0; chan_sel = 3'd0; delay_code = 4'd0; rate_code = 2'd0;
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk("R1 strobe after reset", sample_strobe, 0);
        chk("R1 result after reset", res_valid, 0);
        chk("R1 tag after reset", res_chan, 0);
        chk("R1 divider after reset", batt_div_en, 0);
        chk("R1 mux after reset", adc_mux, 0);

        // R2: powered down, nothing happens
        chk("R2 pen detect off", pen_det_en, 0);
        chan_sel = 3'd2; delay_code = 4'd1; cont_en = 1'b1;
        pulse_poll();
        s = 0; r = 0; b = 0;
        for (int k = 0; k < 6; k++) begin
            tick();
            s += sample_strobe; r += res_valid; b += batt_div_en;
        end
        chk("R2 no strobe when off", s, 0);
        chk("R2 no result when off", r, 0);
        chk("R2 no divider when off", b, 0);
        cont_en = 1'b0;
        power_mode = 2'b01;
        @(negedge clk);
        chk("R2 pen detect on", pen_det_en, 1);

        // R4 R5 R8: battery poll, delay 3
        poll_run(3'd2, 4'd3, 2'd0, s, r, t, b, m);
        chk("R4 battery strobe tick", s, exp_strobe(3, 1));
        chk("R5 battery result tick", r, exp_strobe(3, 1) + 1);
        chk("R5 battery tag", t, 2);
        chk("R8 divider frames d3", b, exp_batt(3, 1));
        chk("R4 mux during settle", m, 2);
        chk("R9 divider off when idle", batt_div_en, 0);

        // R4 R9: aux poll delay 0
        poll_run(3'd1, 4'd0, 2'd0, s, r, t, b, m);
        chk("R4 delay0 strobe tick", s, 2);
        chk("R5 delay0 result tick", r, 3);
        chk("R9 no divider aux", b, 0);

        // R8: battery delay 0 still two frames
        poll_run(3'd2, 4'd0, 2'd0, s, r, t, b, m);
        chk("R8 battery min frames", b, 2);

        // R6: hold, non-battery
        poll_run(3'd4, 4'd15, 2'd0, s, r, t, b, m);
        chk("R6 hold strobe on start tick", s, 1);
        chk("R5 hold result tick", r, 2);
        chk("R5 hold tag", t, 4);
        chk("R6 hold mux", m, 4);
        chan_sel = 3'd3;
        @(negedge clk);
        chk("R6 mux follows select", adc_mux, 3);

        // R8: hold battery gets a settling frame
        poll_run(3'd2, 4'd15, 2'd0, s, r, t, b, m);
        chk("R8 hold battery strobe", s, 2);
        chk("R8 hold battery divider", b, 2);

        // R3: invalid channel codes
        foreach (t_codes[i]) ;
        for (int c = 0; c < 8; c += 5) begin
            chan_sel = 3'(c == 0 ? 0 : 6); delay_code = 4'd1; cont_en = 1'b0;
            pulse_poll();
            s = 0;
            for (int k = 0; k < 6; k++) begin tick(); s += sample_strobe; end
            chk("R3 invalid channel ignored", s, 0);
        end

        // R10: poll during busy conversion
        chan_sel = 3'd1; delay_code = 4'd2; rate_code = 2'd0; cont_en = 1'b0;
        pulse_poll();
        s1 = 0; s2 = 0;
        for (int k = 1; k <= 14; k++) begin
            tick();
            if (k == 1) pulse_poll();
            if (sample_strobe) begin if (s1 == 0) s1 = k; else if (s2 == 0) s2 = k; end
        end
        chk("R10 first strobe", s1, 4);
        chk("R10 queued strobe", s2, 9);

        // R11: rate code ignored in poll mode
        poll_run(3'd3, 4'd1, 2'd3, s, r, t, b, m);
        chk("R11 poll latency rate3", s, 3);
        poll_run(3'd3, 4'd15, 2'd3, s, r, t, b, m);
        chk("R11 hold poll rate3 first", s, 1);
        poll_run(3'd3, 4'd15, 2'd3, s, r, t, b, m);
        chk("R11 hold poll rate3 second", s, 1);

        // R7 R13: continuous hold rates
        for (int rt = 0; rt < 4; rt++) begin
            cont_run(3'd1, 4'd15, 2'(rt), s1, s2, ns, nr);
            chk("R7 continuous spacing", s2 - s1, exp_period(15, rt));
            chk("R7 first strobe on first tick", s1, 1);
            if (rt == 0) begin
                chk("R13 one strobe each frame", ns, 16);
                chk("R5 results each frame", nr, 15);
            end
        end

        // R12: continuous without hold
        for (int d = 0; d < 5; d += 2) begin
            cont_run(3'd4, 4'(d), 2'd1, s1, s2, ns, nr);
            chk("R12 continuous period", s2 - s1, exp_period(d, 1));
        end

        // R2: power down during battery conversion drops it
        chan_sel = 3'd2; delay_code = 4'd5; cont_en = 1'b0;
        pulse_poll();
        tick(); tick();
        chk("R8 divider mid conversion", batt_div_en, 1);
        power_mode = 2'b00;
        tick();
        chk("R2 divider dropped", batt_div_en, 0);
        power_mode = 2'b10;
        s = 0; r = 0;
        for (int k = 0; k < 10; k++) begin tick(); s += sample_strobe; r += res_valid; end
        chk("R2 aborted conversion no strobe", s, 0);
        chk("R2 aborted conversion no result", r, 0);

        // random mix of channel, delay, rate
        for (int it = 0; it < 24; it++) begin
            logic [2:0] ch;
            logic [3:0] dd;
            logic [1:0] rr;
            ch = 3'(1 + ($urandom % 4));
            dd = (($urandom % 3) == 0) ? 4'd15 : 4'($urandom % 8);
            rr = 2'($urandom % 4);
            poll_run(ch, dd, rr, s, r, t, b, m);
            chk("R4 random strobe", s, exp_strobe(int'(dd), ch == 3'd2));
            chk("R5 random result", r, exp_strobe(int'(dd), ch == 3'd2) + 1);
            chk("R5 random tag", t, int'(ch));
            chk("R8 random divider", b, exp_batt(int'(dd), ch == 3'd2));
        end

        done = 1;
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    int t_codes[1];
endmodule